// File: doc/BRIEF.md
# Instrument Status Byte and Event Register Logic

This block holds the status byte that a bus controller reads by serial poll, together with the event registers behind it. Each of the eight byte positions has its own rule. Some positions follow a live level from the instrument core, such as the alarm condition, the command-busy flag, the scan count and the output-queue state. Others latch: trigger detected and buffer overrun stay set until a specific clearing event.

One position summarises a second tier of registers. An event status register collects sticky error bits from one-cycle event pulses, and an enable register masks those bits. The summary bit in the status byte is the OR of the masked events. A third tier, the cause register, records detail pulses behind one chosen event bit. Reading the cause register clears that event bit, so the summary drops once the root cause has been read.

Software reaches the registers through a plain read/write port: a write strobe, a read strobe, a 2-bit address and byte data. Read data is combinational from the current state. Any clear that a read causes takes effect at the clock edge that ends the read cycle. The port is unbuffered, so it has no back-pressure: every strobe is accepted in the cycle it is given.

Top module: `status_byte_unit`

## Requirements
- R1: Status byte bit layout is: bit0 alarm, bit1 trigger detected, bit2 ready, bit3 scan available, bit4 message available, bit5 event summary, bit6 reserved (always 0), bit7 buffer overrun. After reset, with the core idle and not busy, the byte reads 0x04.
- R2: Bit0 equals alarm_i in the same cycle, with no latching.
- R3: Bit1 sets, visible the cycle after trig_seen_i is high. It holds until acq_done_i or trig_cfg_wr_i is high, and clears the cycle after that. If set and clear happen in the same cycle, set wins.
- R4: In the same cycle as their inputs: bit2 is the inverse of busy_i, bit3 is 1 when scan_count_i is nonzero, and bit4 is the inverse of outq_empty_i.
- R5: Bit7 sets the cycle after overrun_i is high. It clears the cycle after a cycle in which scan_count_i is 0 or buf_reset_i is high. Set wins over clear.
- R6: Bit5 equals the OR over all bits of (event status AND enable). A write at address 2 loads the enable register, and bit5 reflects the new mask from the next cycle. Writes at addresses 0, 1 and 3 change nothing.
- R7: Event status bits set on evt_pulse_i and stay set. A read at address 1 returns them and clears all of them at that edge. A pulse in the same cycle as the read leaves its bit set.
- R8: A nonzero cause_pulse_i sets the matching cause register bits and sets event status bit 4. A read at address 3 returns the cause register and clears it and event bit 4 only. New pulses in the same cycle as the read are kept.
- R9: A read at address 0 returns the status byte, and a read at address 2 returns the enable register. Neither changes any state.
- R10: A synchronous reset (rst_n low at a clock edge) clears the trigger, overrun, event status, enable and cause registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alarm_i | input | 1 | Live alarm condition |
| trig_seen_i | input | 1 | Trigger condition detected (pulse) |
| acq_done_i | input | 1 | Acquisition complete (pulse) |
| trig_cfg_wr_i | input | 1 | Trigger configuration rewritten (pulse) |
| busy_i | input | 1 | Command line being processed |
| scan_count_i | input | CNT_W | Scans held in acquisition buffer |
| outq_empty_i | input | 1 | Output queue empty |
| overrun_i | input | 1 | Buffer overrun occurred (pulse) |
| buf_reset_i | input | 1 | Buffer reset command (pulse) |
| evt_pulse_i | input | 8 | Event status set pulses, one per bit |
| cause_pulse_i | input | 8 | Cause detail set pulses behind event bit 4 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | 0 status byte, 1 event status, 2 enable, 3 cause |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register |
| poll_byte_o | output | 8 | Status byte for serial poll |

## Verification
The stimulus is mostly random and sparse. Latching inputs pulse rarely, so the trigger and overrun bits spend long runs set and show whether they hold. Live levels toggle freely, so any unwanted latching of them shows up. Random reads and writes at all four addresses separate clearing from non-clearing reads, and separate the enable address from writes that must be ignored. Directed cases force the same-cycle set/clear collisions on the trigger, overrun, event and cause registers, and a mid-run reset, where a wrong priority or a missed clear shows up at once.

// File: rtl/status_pkg.sv
package status_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  typedef logic [DATA_W-1:0] byte_t;

  localparam logic [ADDR_W-1:0] A_POLL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_EVT   = 2'd1;
  localparam logic [ADDR_W-1:0] A_MASK  = 2'd2;
  localparam logic [ADDR_W-1:0] A_CAUSE = 2'd3;

  localparam int B_ALARM = 0;
  localparam int B_TRIG  = 1;
  localparam int B_READY = 2;
  localparam int B_SCAN  = 3;
  localparam int B_MAV   = 4;
  localparam int B_SUM   = 5;
  localparam int B_RSV   = 6;
  localparam int B_OVR   = 7;
endpackage

// File: rtl/sb_level_bits.sv
module sb_level_bits
  import status_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alarm_i,
  input  logic             trig_seen_i,
  input  logic             acq_done_i,
  input  logic             trig_cfg_wr_i,
  input  logic             busy_i,
  input  logic [CNT_W-1:0] scan_count_i,
  input  logic             outq_empty_i,
  input  logic             overrun_i,
  input  logic             buf_reset_i,
  output byte_t            lvl_byte_o
);
  logic trig_q;
  logic ovr_q;
  logic buf_empty;

  assign buf_empty = (scan_count_i == '0);

  // Trigger latch: a new trigger beats a same-cycle clear.
  always_ff @(posedge clk) begin
    if (!rst_n)                            trig_q <= 1'b0;
    else if (trig_seen_i)                  trig_q <= 1'b1;
    else if (acq_done_i || trig_cfg_wr_i)  trig_q <= 1'b0;
  end

  // Overrun latch: cleared by an empty buffer or a buffer reset.
  always_ff @(posedge clk) begin
    if (!rst_n)                         ovr_q <= 1'b0;
    else if (overrun_i)                 ovr_q <= 1'b1;
    else if (buf_empty || buf_reset_i)  ovr_q <= 1'b0;
  end

  always_comb begin
    lvl_byte_o          = '0;
    lvl_byte_o[B_ALARM] = alarm_i;
    lvl_byte_o[B_TRIG]  = trig_q;
    lvl_byte_o[B_READY] = ~busy_i;
    lvl_byte_o[B_SCAN]  = ~buf_empty;
    lvl_byte_o[B_MAV]   = ~outq_empty_i;
    lvl_byte_o[B_OVR]   = ovr_q;
  end

  assert_trig_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q && !acq_done_i && !trig_cfg_wr_i) |=> trig_q);

  assert_trig_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trig_seen_i |=> lvl_byte_o[B_TRIG]);

  assert_ovr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((scan_count_i == '0 || buf_reset_i) && !overrun_i) |=> !lvl_byte_o[B_OVR]);

  assert_ovr_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_i |=> ovr_q);
endmodule

// File: rtl/sb_event_regs.sv
module sb_event_regs
  import status_pkg::*;
#(
  parameter int ERR_BIT = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  byte_t evt_pulse_i,
  input  byte_t cause_pulse_i,
  input  logic  mask_wr_i,
  input  byte_t mask_wdata_i,
  input  logic  clr_all_i,
  input  logic  clr_cause_i,
  output byte_t esr_o,
  output byte_t mask_o,
  output byte_t cause_o,
  output logic  summary_o
);
  byte_t esr_q, mask_q, cause_q;
  byte_t esr_set, esr_clr;

  always_comb begin
    esr_set          = evt_pulse_i;
    esr_set[ERR_BIT] = evt_pulse_i[ERR_BIT] | (|cause_pulse_i);
    esr_clr          = '0;
    if (clr_all_i)        esr_clr = '1;
    else if (clr_cause_i) esr_clr[ERR_BIT] = 1'b1;
  end

  // Set pulses win over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      esr_q   <= '0;
      mask_q  <= '0;
      cause_q <= '0;
    end else begin
      esr_q   <= (esr_q & ~esr_clr) | esr_set;
      cause_q <= (clr_cause_i ? '0 : cause_q) | cause_pulse_i;
      if (mask_wr_i) mask_q <= mask_wdata_i;
    end
  end

  assign esr_o     = esr_q;
  assign mask_o    = mask_q;
  assign cause_o   = cause_q;
  assign summary_o = |(esr_q & mask_q);

  assert_esr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_all_i && !clr_cause_i) |=> ((esr_q & $past(esr_q)) == $past(esr_q)));

  assert_esr_clrall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all_i && evt_pulse_i == '0 && cause_pulse_i == '0) |=> (esr_q == '0));

  assert_cause_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_cause_i && !clr_all_i && evt_pulse_i == '0 && cause_pulse_i == '0)
      |=> (cause_q == '0 && !esr_q[ERR_BIT]));
endmodule

// File: rtl/status_byte_unit.sv
module status_byte_unit
  import status_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int ERR_BIT = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alarm_i,
  input  logic                    trig_seen_i,
  input  logic                    acq_done_i,
  input  logic                    trig_cfg_wr_i,
  input  logic                    busy_i,
  input  logic [CNT_W-1:0]        scan_count_i,
  input  logic                    outq_empty_i,
  input  logic                    overrun_i,
  input  logic                    buf_reset_i,
  input  logic [DATA_W-1:0]       evt_pulse_i,
  input  logic [DATA_W-1:0]       cause_pulse_i,
  input  logic                    reg_wr_i,
  input  logic                    reg_rd_i,
  input  logic [ADDR_W-1:0]       reg_addr_i,
  input  logic [DATA_W-1:0]       reg_wdata_i,
  output logic [DATA_W-1:0]       reg_rdata_o,
  output logic [DATA_W-1:0]       poll_byte_o
);
  byte_t lvl_byte, esr_w, mask_w, cause_w;
  logic  summary_w;
  logic  mask_wr, clr_all, clr_cause;

  assign mask_wr   = reg_wr_i && (reg_addr_i == A_MASK);
  assign clr_all   = reg_rd_i && (reg_addr_i == A_EVT);
  assign clr_cause = reg_rd_i && (reg_addr_i == A_CAUSE);

  sb_level_bits #(.CNT_W(CNT_W)) u_lvl (
    .clk           (clk),
    .rst_n         (rst_n),
    .alarm_i       (alarm_i),
    .trig_seen_i   (trig_seen_i),
    .acq_done_i    (acq_done_i),
    .trig_cfg_wr_i (trig_cfg_wr_i),
    .busy_i        (busy_i),
    .scan_count_i  (scan_count_i),
    .outq_empty_i  (outq_empty_i),
    .overrun_i     (overrun_i),
    .buf_reset_i   (buf_reset_i),
    .lvl_byte_o    (lvl_byte)
  );

  sb_event_regs #(.ERR_BIT(ERR_BIT)) u_evt (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_pulse_i   (evt_pulse_i),
    .cause_pulse_i (cause_pulse_i),
    .mask_wr_i     (mask_wr),
    .mask_wdata_i  (reg_wdata_i),
    .clr_all_i     (clr_all),
    .clr_cause_i   (clr_cause),
    .esr_o         (esr_w),
    .mask_o        (mask_w),
    .cause_o       (cause_w),
    .summary_o     (summary_w)
  );

  always_comb begin
    poll_byte_o        = lvl_byte;
    poll_byte_o[B_SUM] = summary_w;
    poll_byte_o[B_RSV] = 1'b0;
  end

  always_comb begin
    case (reg_addr_i)
      A_POLL:  reg_rdata_o = poll_byte_o;
      A_EVT:   reg_rdata_o = esr_w;
      A_MASK:  reg_rdata_o = mask_w;
      default: reg_rdata_o = cause_w;
    endcase
  end

  assert_mask_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == A_MASK && reg_wdata_i == '0) |=> !poll_byte_o[B_SUM]);

  assert_poll_read_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && reg_addr_i == A_POLL && evt_pulse_i == '0 && cause_pulse_i == '0)
      |=> (esr_w == $past(esr_w) && cause_w == $past(cause_w)));

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && reg_addr_i == A_MASK) |=> $stable(mask_w));

  assert_rsv_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(esr_w[B_RSV]) |-> !poll_byte_o[B_RSV]);
endmodule

// File: tb/status_byte_unit_bench.sv
module status_byte_unit_bench;
  typedef struct packed {
    logic       rst_n, alarm, trig_seen, acq_done, cfg_wr, busy;
    logic [7:0] cnt;
    logic       oq_empty, ovr, buf_rst;
    logic [7:0] evt, cause;
    logic       wr, rd;
    logic [1:0] addr;
    logic [7:0] wdata;
  } drv_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alarm_i = 0, trig_seen_i = 0, acq_done_i = 0, trig_cfg_wr_i = 0, busy_i = 0;
  logic [7:0] scan_count_i = 0;
  logic outq_empty_i = 1, overrun_i = 0, buf_reset_i = 0;
  logic [7:0] evt_pulse_i = 0, cause_pulse_i = 0;
  logic reg_wr_i = 0, reg_rd_i = 0;
  logic [1:0] reg_addr_i = 0;
  logic [7:0] reg_wdata_i = 0;
  logic [7:0] reg_rdata_o, poll_byte_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic       m_trig = 0, m_ovr = 0;
  logic [7:0] m_esr = 0, m_ese = 0, m_cause = 0;

  always #10 clk = ~clk;

  status_byte_unit u_status_byte_unit (
    .clk(clk), .rst_n(rst_n), .alarm_i(alarm_i), .trig_seen_i(trig_seen_i),
    .acq_done_i(acq_done_i), .trig_cfg_wr_i(trig_cfg_wr_i), .busy_i(busy_i),
    .scan_count_i(scan_count_i), .outq_empty_i(outq_empty_i), .overrun_i(overrun_i),
    .buf_reset_i(buf_reset_i), .evt_pulse_i(evt_pulse_i), .cause_pulse_i(cause_pulse_i),
    .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .poll_byte_o(poll_byte_o)
  );

  function automatic drv_t idle();
    drv_t d = '0;
    d.rst_n = 1'b1;
    d.oq_empty = 1'b1;
    return d;
  endfunction

  function automatic logic [7:0] exp_byte(drv_t d);
    return {m_ovr, 1'b0, |(m_esr & m_ese), ~d.oq_empty, d.cnt != 0, ~d.busy, m_trig, d.alarm};
  endfunction

  function automatic logic [7:0] exp_rdata(drv_t d);
    case (d.addr)
      2'd0: return exp_byte(d);
      2'd1: return m_esr;
      2'd2: return m_ese;
      default: return m_cause;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input drv_t d);
    logic [7:0] eb, clr, setv;
    @(negedge clk);
    rst_n = d.rst_n; alarm_i = d.alarm; trig_seen_i = d.trig_seen; acq_done_i = d.acq_done;
    trig_cfg_wr_i = d.cfg_wr; busy_i = d.busy; scan_count_i = d.cnt; outq_empty_i = d.oq_empty;
    overrun_i = d.ovr; buf_reset_i = d.buf_rst; evt_pulse_i = d.evt; cause_pulse_i = d.cause;
    reg_wr_i = d.wr; reg_rd_i = d.rd; reg_addr_i = d.addr; reg_wdata_i = d.wdata;
    #2;
    eb = exp_byte(d);
    chk("R2 alarm bit", {7'b0, poll_byte_o[0]}, {7'b0, eb[0]});
    chk("R3 trigger bit", {7'b0, poll_byte_o[1]}, {7'b0, eb[1]});
    chk("R4 ready/scan/mav bits", {5'b0, poll_byte_o[4:2]}, {5'b0, eb[4:2]});
    chk("R6 summary bit", {7'b0, poll_byte_o[5]}, {7'b0, eb[5]});
    chk("R1 reserved bit", {7'b0, poll_byte_o[6]}, 8'h00);
    chk("R5 overrun bit", {7'b0, poll_byte_o[7]}, {7'b0, eb[7]});
    case (d.addr)
      2'd0: chk("R9 status read", reg_rdata_o, exp_rdata(d));
      2'd1: chk("R7 event read", reg_rdata_o, exp_rdata(d));
      2'd2: chk("R9 enable read", reg_rdata_o, exp_rdata(d));
      default: chk("R8 cause read", reg_rdata_o, exp_rdata(d));
    endcase
    @(posedge clk);
    if (!d.rst_n) begin
      m_trig = 0; m_ovr = 0; m_esr = 0; m_ese = 0; m_cause = 0;
    end else begin
      if (d.trig_seen) m_trig = 1;
      else if (d.acq_done || d.cfg_wr) m_trig = 0;
      if (d.ovr) m_ovr = 1;
      else if (d.cnt == 0 || d.buf_rst) m_ovr = 0;
      clr = 8'h00;
      if (d.rd && d.addr == 2'd1) clr = 8'hFF;
      else if (d.rd && d.addr == 2'd3) clr = 8'h10;
      setv = d.evt | ((d.cause != 0) ? 8'h10 : 8'h00);
      m_esr = (m_esr & ~clr) | setv;
      m_cause = ((d.rd && d.addr == 2'd3) ? 8'h00 : m_cause) | d.cause;
      if (d.wr && d.addr == 2'd2) m_ese = d.wdata;
    end
  endtask

  function automatic drv_t rnd();
    drv_t d = idle();
    d.alarm = $urandom_range(0, 1);
    d.trig_seen = ($urandom_range(0, 7) == 0);
    d.acq_done = ($urandom_range(0, 7) == 0);
    d.cfg_wr = ($urandom_range(0, 15) == 0);
    d.busy = $urandom_range(0, 1);
    d.cnt = ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom_range(1, 255));
    d.oq_empty = $urandom_range(0, 1);
    d.ovr = ($urandom_range(0, 15) == 0);
    d.buf_rst = ($urandom_range(0, 15) == 0);
    d.evt = 8'($urandom & $urandom & $urandom & $urandom);
    d.cause = ($urandom_range(0, 15) == 0) ? 8'($urandom) : 8'h00;
    d.wr = ($urandom_range(0, 7) == 0);
    d.rd = ($urandom_range(0, 3) == 0);
    d.addr = 2'($urandom_range(0, 3));
    d.wdata = 8'($urandom);
    return d;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    drv_t d;
    void'($urandom(32'h5eed_0042));
    d = idle(); d.rst_n = 0;
    step(d); step(d);
    // R1: reset value with idle core
    d = idle();
    step(d);
    chk("R1 reset byte", poll_byte_o, 8'h04);
    // R3: set wins over same-cycle clear
    d = idle(); d.trig_seen = 1; d.acq_done = 1; step(d);
    d = idle(); step(d);
    chk("R3 set beats clear", {7'b0, poll_byte_o[1]}, 8'h01);
    d = idle(); d.cfg_wr = 1; step(d);
    // R5: overrun with empty buffer, then hold and drain
    d = idle(); d.ovr = 1; step(d);
    d = idle(); d.cnt = 8'd5; step(d);
    chk("R5 overrun latched", {7'b0, poll_byte_o[7]}, 8'h01);
    d = idle(); d.cnt = 8'd5; step(d);
    d = idle(); step(d);
    // R8: cause pulse, enable bit 4, read cause clears only bit 4
    d = idle(); d.cause = 8'h06; d.evt = 8'h01; step(d);
    d = idle(); d.wr = 1; d.addr = 2'd2; d.wdata = 8'h10; step(d);
    d = idle(); d.wr = 1; d.addr = 2'd0; d.wdata = 8'h00; step(d);
    chk("R6 summary set, write to addr 0 ignored", poll_byte_o, 8'h24);
    d = idle(); d.rd = 1; d.addr = 2'd3; step(d);
    d = idle(); d.addr = 2'd1; step(d);
    chk("R8 only bit4 cleared", reg_rdata_o, 8'h01);
    chk("R8 summary dropped", poll_byte_o, 8'h04);
    // R7: read of event register with a same-cycle pulse
    d = idle(); d.rd = 1; d.addr = 2'd1; d.evt = 8'h80; step(d);
    d = idle(); d.addr = 2'd1; step(d);
    chk("R7 same-cycle pulse kept", reg_rdata_o, 8'h80);
    // random phase
    for (int i = 0; i < 3000; i++) step(rnd());
    // R10: mid-run reset
    d = idle(); d.evt = 8'hFF; d.trig_seen = 1; d.ovr = 1; d.cnt = 8'd3;
    d.wr = 1; d.addr = 2'd2; d.wdata = 8'hFF; step(d);
    d = idle(); d.rst_n = 0; step(d);
    d = idle(); d.addr = 2'd1; step(d);
    chk("R10 event cleared by reset", reg_rdata_o, 8'h00);
    chk("R10 byte after reset", poll_byte_o, 8'h04);
    for (int i = 0; i < 1000; i++) step(rnd());
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule